// File: doc/BRIEF.md
# Mailbox Send-Side Register Block

This block is the transmit half of an inter-processor mailbox with a parameterised number of channels (eight by default). A local processor reaches it through a single-cycle 32-bit register bus. To send, software does four writes: a destination channel number, the low and high words of a 64-bit message, and then a write to the trigger register. The trigger stores the message in that channel's slot, and the channel stays busy until the remote side fetches it.

The remote core is modelled by two things. A per-channel fetch pulse marks a message as taken. A peek port lets the remote side read a channel's stored message. The block records three flags for each channel: busy, delivered and overflow. It packs all of them into one status word. Software clears the delivered and overflow flags selectively through a separate clear register.

Three event kinds can raise a single sticky interrupt, and each kind has its own mask bit. A test-and-set lock register lets the two processors share the block.

Top module: `mbx_send_ctrl`

## Requirements
- R1: After reset the status word (0x14) reads 0, the mask (0x1C) reads 7, the interrupt status (0x18) reads 0, `irq` is low, and channel (0x00), low word (0x04) and high word (0x08) read 0.
- R2: A write to 0x00, 0x04 or 0x08 is returned by a read of the same offset. Read data appears on `bus_rdata` one clock after the read strobe.
- R3: A write of any value to 0x0C while the selected channel is idle sets that channel's busy bit, at status bit `ch`. The 64-bit message is then returned on `peek_msg` one clock after `peek_ch` selects that channel.
- R4: A write to 0x0C while the selected channel is busy sets its overflow bit, at status bit `8+ch`. The stored message and the busy bit are left unchanged.
- R5: A fetch pulse on a busy channel clears its busy bit and sets its delivered bit, at status bit `16+ch`. A fetch pulse on an idle channel changes nothing.
- R6: A write to 0x10 clears every delivered flag whose position is set in bits 23:16 of the written value. It clears every overflow flag whose position is set in bits 15:8. Busy flags are not affected.
- R7: The interrupt status bit 0 becomes 1 when an event occurs whose mask bit (0x1C) is 0. The mask bits are: bit 0 for an accepted send, bit 1 for an overflow, bit 2 for a delivery. An event whose mask bit is 1 leaves the interrupt status unchanged.
- R8: Once set, the interrupt status bit and `irq` stay set until 0x18 is written with bit 0 equal to 1. A write to 0x18 with bit 0 equal to 0 has no effect.
- R9: Reading 0x20 returns 0 when the lock is free and 1 when it is held, and every such read leaves the lock held. A write of 0 to 0x20 frees the lock; a write of any nonzero value has no effect.
- R10: Reading 0x24 returns the number of channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fetch | input | NUM_CH | Per-channel fetch pulse from the remote side |
| peek_ch | input | CH_W | Channel whose stored message is read out |
| peek_msg | output | 64 | Stored message of `peek_ch`, one clock later |
| irq | output | 1 | Sticky interrupt |

## Verification
Any flag the block holds reaches the status word. A wrong busy, overflow or delivered bit therefore shows on the first status read after the cycle that corrupted it. A wrong busy bit also spreads: it turns the next send into an overflow, or the next send overflows where it should have been accepted, so the error shows in two flags. A wrong interrupt decision shows on `irq` one clock after the event. The bench reads the full status word and `irq` after every random operation, so a divergence from the model is reported at the operation that caused it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [5:0] {
    OFS_CHAN  = 6'h00,
    OFS_LO    = 6'h04,
    OFS_HI    = 6'h08,
    OFS_SEND  = 6'h0C,
    OFS_CLR   = 6'h10,
    OFS_STAT  = 6'h14,
    OFS_ISTAT = 6'h18,
    OFS_IMASK = 6'h1C,
    OFS_LOCK  = 6'h20,
    OFS_CAP   = 6'h24
  } mbx_ofs_e;

  // interrupt source indices
  localparam int EV_ACCEPT  = 0;
  localparam int EV_OVF     = 1;
  localparam int EV_DELIVER = 2;
  localparam int EV_NUM     = 3;

  // fields of the packed status word
  localparam int STAT_BUSY_LSB = 0;
  localparam int STAT_OVF_LSB  = 8;
  localparam int STAT_DLV_LSB  = 16;
endpackage

// File: rtl/mbx_slot_store.sv
module mbx_slot_store #(
  parameter int NUM_CH = 8,
  parameter int MSG_W  = 64,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [MSG_W-1:0] wr_msg,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [MSG_W-1:0] rd_msg
);
  // one message slot per channel: a plain array, so block RAM can be inferred
  logic [MSG_W-1:0] slots [NUM_CH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ch] <= wr_msg;
  end

  always_ff @(posedge clk) begin
    rd_msg <= slots[rd_ch];
  end
endmodule

// File: rtl/mbx_chan_flags.sv
module mbx_chan_flags #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send,
  input  logic [CH_W-1:0]   send_ch,
  input  logic [NUM_CH-1:0] fetch,
  input  logic              clr_wr,
  input  logic [NUM_CH-1:0] clr_dlv,
  input  logic [NUM_CH-1:0] clr_ovf,
  output logic [NUM_CH-1:0] busy,
  output logic [NUM_CH-1:0] ovf,
  output logic [NUM_CH-1:0] dlv,
  output logic              accept,
  output logic              ev_ovf,
  output logic              ev_dlv
);
  logic [NUM_CH-1:0] hit;

  assign accept = send && !busy[send_ch];
  assign ev_ovf = send && busy[send_ch];
  assign ev_dlv = |(fetch & busy);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hit[c] = send && (send_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        busy[c] <= 1'b0;
        ovf[c]  <= 1'b0;
        dlv[c]  <= 1'b0;
      end else begin
        busy[c] <= (busy[c] && !fetch[c]) || (hit[c] && !busy[c]);
        ovf[c]  <= (ovf[c] && !(clr_wr && clr_ovf[c])) || (hit[c] && busy[c]);
        dlv[c]  <= (dlv[c] && !(clr_wr && clr_dlv[c])) || (fetch[c] && busy[c]);
      end
    end

    // R3: a send to an idle channel leaves it busy
    assert_busy_on_send_R3: assert property (@(posedge clk) disable iff (rst)
      (hit[c] && !busy[c]) |=> busy[c]);
    // R4: a send to a busy channel marks overflow and keeps it busy
    assert_ovf_on_busy_R4: assert property (@(posedge clk) disable iff (rst)
      (hit[c] && busy[c] && !fetch[c]) |=> (ovf[c] && busy[c]));
    // R5: a fetch of a pending message frees the channel and marks delivery
    assert_fetch_delivers_R5: assert property (@(posedge clk) disable iff (rst)
      (fetch[c] && busy[c] && !hit[c]) |=> (!busy[c] && dlv[c]));
    // R6: the clear register never touches busy
    assert_clr_keeps_busy_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && !hit[c] && !fetch[c]) |=> $stable(busy[c]));
  end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic [EV_NUM-1:0] mask_wdata,
  input  logic              clr,
  input  logic [EV_NUM-1:0] events,
  output logic [EV_NUM-1:0] mask,
  output logic              pend
);
  logic raise;
  assign raise = |(events & ~mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      pend <= 1'b0;
    end else begin
      if (mask_wr) mask <= mask_wdata;
      pend <= raise || (pend && !clr);
    end
  end

  // R8: the pending bit holds until an explicit clear
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
  // R7: with no unmasked event the pending bit cannot rise
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (!pend && !raise) |=> !pend);
endmodule

// File: rtl/mbx_send_ctrl.sv
module mbx_send_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int MSG_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] fetch,
  input  logic [CH_W-1:0]   peek_ch,
  output logic [MSG_W-1:0]  peek_msg,
  output logic              irq
);
  logic [CH_W-1:0]   chan_q;
  logic [31:0]       lo_q, hi_q;
  logic              lock_q;
  logic              send, clr_wr, irq_clr, mask_wr;
  logic [NUM_CH-1:0] busy, ovf, dlv;
  logic              accept, ev_ovf, ev_dlv;
  logic [EV_NUM-1:0] events, mask;
  logic              pend;
  logic [7:0]        busy8, ovf8, dlv8;
  logic [31:0]       rd_next;

  assign send    = bus_wr && (bus_addr == OFS_SEND);
  assign clr_wr  = bus_wr && (bus_addr == OFS_CLR);
  assign irq_clr = bus_wr && (bus_addr == OFS_ISTAT) && bus_wdata[0];
  assign mask_wr = bus_wr && (bus_addr == OFS_IMASK);

  // staging registers
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CHAN: chan_q <= bus_wdata[CH_W-1:0];
        OFS_LO:   lo_q   <= bus_wdata;
        OFS_HI:   hi_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  // test-and-set lock
  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else if (bus_rd && bus_addr == OFS_LOCK) lock_q <= 1'b1;
    else if (bus_wr && bus_addr == OFS_LOCK && bus_wdata == '0) lock_q <= 1'b0;
  end

  mbx_chan_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .send(send), .send_ch(chan_q), .fetch(fetch),
    .clr_wr(clr_wr),
    .clr_dlv(bus_wdata[STAT_DLV_LSB +: NUM_CH]),
    .clr_ovf(bus_wdata[STAT_OVF_LSB +: NUM_CH]),
    .busy(busy), .ovf(ovf), .dlv(dlv),
    .accept(accept), .ev_ovf(ev_ovf), .ev_dlv(ev_dlv)
  );

  mbx_slot_store #(.NUM_CH(NUM_CH), .MSG_W(MSG_W)) u_store (
    .clk(clk), .wr_en(accept), .wr_ch(chan_q), .wr_msg({hi_q, lo_q}),
    .rd_ch(peek_ch), .rd_msg(peek_msg)
  );

  always_comb begin
    events = '0;
    events[EV_ACCEPT]  = accept;
    events[EV_OVF]     = ev_ovf;
    events[EV_DELIVER] = ev_dlv;
  end

  mbx_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .mask_wr(mask_wr),
    .mask_wdata(bus_wdata[EV_NUM-1:0]), .clr(irq_clr),
    .events(events), .mask(mask), .pend(pend)
  );

  assign irq = pend;

  always_comb begin
    busy8 = '0; ovf8 = '0; dlv8 = '0;
    busy8[NUM_CH-1:0] = busy;
    ovf8[NUM_CH-1:0]  = ovf;
    dlv8[NUM_CH-1:0]  = dlv;
    rd_next = '0;
    case (bus_addr)
      OFS_CHAN:  rd_next[CH_W-1:0] = chan_q;
      OFS_LO:    rd_next = lo_q;
      OFS_HI:    rd_next = hi_q;
      OFS_STAT:  rd_next = {8'h00, dlv8, ovf8, busy8};
      OFS_ISTAT: rd_next[0] = pend;
      OFS_IMASK: rd_next[EV_NUM-1:0] = mask;
      OFS_LOCK:  rd_next[0] = lock_q;
      OFS_CAP:   rd_next = 32'(NUM_CH);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R9: any read of the lock register leaves it held
  assert_lock_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_LOCK) |=> lock_q);
  // R9: a nonzero write never frees a held lock
  assert_lock_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !(bus_wr && bus_addr == OFS_LOCK && bus_wdata == '0)) |=> lock_q);
endmodule

// File: tb/mbx_send_ctrl_tb.sv
module mbx_send_ctrl_tb;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] fetch = '0;
  logic [2:0]  peek_ch = '0;
  logic [63:0] peek_msg;
  logic        irq;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  // model
  logic [7:0]  m_busy, m_ovf, m_dlv;
  logic [2:0]  m_mask, m_ch;
  logic        m_pend;
  logic [31:0] m_lo, m_hi;
  logic [63:0] m_mem [NCH];

  always #2.5 clk = ~clk;

  mbx_send_ctrl #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fetch(fetch),
    .peek_ch(peek_ch), .peek_msg(peek_msg), .irq(irq)
  );

  function automatic logic [31:0] exp_status();
    return {8'h00, m_dlv, m_ovf, m_busy};
  endfunction

  function automatic logic ev_raises(logic [2:0] ev);
    return |(ev & ~m_mask);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic peek(logic [2:0] c, output logic [63:0] m);
    @(negedge clk); peek_ch = c;
    @(negedge clk); m = peek_msg;
  endtask

  // model-tracking operations
  task automatic op_chan(logic [2:0] c); wr(6'h00, 32'(c)); m_ch = c; endtask
  task automatic op_msg(logic [31:0] lo, logic [31:0] hi);
    wr(6'h04, lo); wr(6'h08, hi); m_lo = lo; m_hi = hi;
  endtask
  task automatic op_send();
    wr(6'h0C, $urandom);
    if (m_busy[m_ch]) begin
      m_ovf[m_ch] = 1; if (ev_raises(3'b010)) m_pend = 1;
    end else begin
      m_busy[m_ch] = 1; m_mem[m_ch] = {m_hi, m_lo};
      if (ev_raises(3'b001)) m_pend = 1;
    end
  endtask
  task automatic op_fetch(logic [2:0] c);
    @(negedge clk); fetch = NCH'(1) << c;
    @(negedge clk); fetch = '0;
    if (m_busy[c]) begin
      m_busy[c] = 0; m_dlv[c] = 1; if (ev_raises(3'b100)) m_pend = 1;
    end
  endtask
  task automatic op_clear(logic [31:0] w);
    wr(6'h10, w); m_dlv &= ~w[23:16]; m_ovf &= ~w[15:8];
  endtask
  task automatic op_mask(logic [2:0] mk); wr(6'h1C, 32'(mk)); m_mask = mk; endtask
  task automatic op_iclr(logic [31:0] w); wr(6'h18, w); if (w[0]) m_pend = 0; endtask

  task automatic check_state(string req);
    logic [31:0] d;
    rd(6'h14, d); check(req, d, exp_status());
    check(req, irq, m_pend);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [63:0] m;
    void'($urandom(32'd20240611));
    m_busy = 0; m_ovf = 0; m_dlv = 0; m_mask = 3'b111; m_ch = 0;
    m_pend = 0; m_lo = 0; m_hi = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(6'h14, d); check("R1 status", d, 0);
    rd(6'h1C, d); check("R1 mask", d, 7);
    rd(6'h18, d); check("R1 istat", d, 0);
    check("R1 irq", irq, 0);
    rd(6'h00, d); check("R1 chan", d, 0);
    rd(6'h04, d); check("R1 lo", d, 0);
    rd(6'h08, d); check("R1 hi", d, 0);
    // R10 capacity
    rd(6'h24, d); check("R10 capacity", d, NCH);

    // R2 staging readback
    op_chan(3'd5); op_msg(32'hDEAD_BEEF, 32'h0123_4567);
    rd(6'h00, d); check("R2 chan", d, 5);
    rd(6'h04, d); check("R2 lo", d, 32'hDEAD_BEEF);
    rd(6'h08, d); check("R2 hi", d, 32'h0123_4567);

    // R3 accepted send, masked: no irq (R7)
    op_send(); check_state("R3 send");
    peek(3'd5, m); check("R3 peek", m, 64'h0123_4567_DEAD_BEEF);
    check("R7 masked send no irq", irq, 0);

    // R4 overflow keeps message
    op_msg(32'h1111_1111, 32'h2222_2222); op_send();
    check_state("R4 overflow");
    peek(3'd5, m); check("R4 message kept", m, 64'h0123_4567_DEAD_BEEF);

    // R5 fetch on idle channel ignored, then real fetch
    op_fetch(3'd2); check_state("R5 idle fetch ignored");
    op_fetch(3'd5); check_state("R5 delivered");

    // R6 selective clear
    op_chan(3'd1); op_send();
    op_clear(32'h0000_2000); check_state("R6 clear wrong bit");
    op_clear(32'h0020_2002); check_state("R6 clear dlv+ovf busy kept");

    // R7 unmasked delivery raises irq; R8 sticky
    op_mask(3'b011); op_fetch(3'd1); check_state("R7 deliver irq");
    check("R7 irq", irq, 1);
    op_iclr(32'h0000_0002); check("R8 zero-bit clear ignored", irq, 1);
    rd(6'h18, d); check("R8 istat held", d, 1);
    op_iclr(32'h1); check("R8 cleared", irq, 0);

    // R9 lock
    rd(6'h20, d); check("R9 first read", d, 0);
    rd(6'h20, d); check("R9 held", d, 1);
    wr(6'h20, 32'h5); rd(6'h20, d); check("R9 nonzero write ignored", d, 1);
    wr(6'h20, 32'h0); rd(6'h20, d); check("R9 released", d, 0);

    // random phase (R3..R8)
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 8)
        0: op_chan(3'($urandom));
        1: op_msg($urandom, $urandom);
        2, 3: op_send();
        4: op_fetch(3'($urandom));
        5: op_clear($urandom);
        6: op_mask(3'($urandom));
        default: op_iclr($urandom);
      endcase
      check_state("R3-R8 random");
      if (i % 16 == 0) begin
        for (int c = 0; c < NCH; c++) if (m_busy[c]) begin
          peek(3'(c), m); check("R3 random peek", m, m_mem[c]);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule